// File: doc/BRIEF.md
# Direct-Mapped Single-Word Cache with Selectable Write Policy

This block sits between a processor load/store port and a main-memory port. It is a direct-mapped cache in which every line carries exactly one data word. The low bits of the address select the line and the remaining high bits are kept as the tag. Each line has a valid flag and a dirty flag, and both clear at reset. A request is accepted on the processor side and acknowledged once. Every memory transfer needed to serve it runs on a request/acknowledge memory port.

Two static configuration inputs set the write behaviour, and each can be chosen without regard to the other. The first decides what a write hit does: update the line and memory together, or update only the line and mark it dirty. The second decides what a write miss does: bring the line in before writing, or send the store straight to memory and leave the line as it was. Before a miss replaces a dirty line, the old word goes back to memory. The new word is fetched only after that. Each lookup raises a one-cycle hit or miss pulse, so the surrounding logic can measure the hit ratio.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ack`, `mem_req`, `hit_pulse` and `miss_pulse` are low, and the first access to any address is a miss.
- R2: The line index is `addr[2:0]` and the tag is `addr[7:3]`. Two addresses with the same index and different tags displace each other, and each line holds one 16-bit word.
- R3: A read hit returns the stored word with no memory request. `cpu_ack` is high in the cycle after the clock edge that accepts the request.
- R4: A read miss whose victim line is invalid or clean issues exactly one memory read, at the requested address and with no memory write. It returns the fetched word and leaves the line valid.
- R5: With `cfg_wb`=0 (write-through), a write hit updates the line and also performs one memory write of the new word at the request address. The line stays clean, so a later replacement of it issues no memory write.
- R6: With `cfg_wb`=1 (write-back), a write hit updates only the line, issues no memory request and marks the line dirty.
- R7: A miss whose victim is valid and dirty first writes the victim word to memory at address {stored tag, index}. It then reads the new address, and the memory write completes before the memory read is issued.
- R8: With `cfg_walloc`=1, a write miss fetches the address into the line and then writes the new word into it. Under write-back no memory write follows; under write-through one memory write at the request address follows.
- R9: With `cfg_walloc`=0, a write miss performs one memory write at the request address, issues no memory read and leaves the line's tag, data and dirty flag unchanged.
- R10: Each accepted request raises exactly one of `hit_pulse` or `miss_pulse`, for one cycle, in the cycle after acceptance. The two are never high together.
- R11: `cpu_ack` is high for one cycle per request. While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wb | input | 1 | Write hit policy: 1 write-back, 0 write-through; change only while idle |
| cfg_walloc | input | 1 | Write miss policy: 1 allocate, 0 write-around; change only while idle |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | 8 | Word address |
| cpu_wdata | input | 16 | Store data |
| cpu_ack | output | 1 | One-cycle completion |
| cpu_rdata | output | 16 | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 memory write, 0 memory read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| hit_pulse | output | 1 | Lookup hit event |
| miss_pulse | output | 1 | Lookup miss event |

## Verification
The lookup takes place on the edge that accepts a request. That edge registers the hit or miss pulse, so the pulse is visible in the following cycle. For hits that need no memory, the acknowledge and read data also appear in that cycle. The bench therefore expects such hits to finish at the first falling edge after the request is driven. Misses and write-through stores depend on the memory latency, which the bench varies with the address. For those, the bench waits for `cpu_ack` at falling edges, then checks the count, kind, address and order of the memory transfers it logged at its own memory model.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FETCH,
        ST_WMEM,
        ST_RESP
    } dmc_state_e;

endpackage

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned TAG_W  = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned LINES = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    line_t [LINES-1:0] lines_d, lines_q;

    always_comb begin
        lines_d = lines_q;
        if (wr_en) begin
            lines_d[wr_idx] = '{valid: wr_valid, dirty: wr_dirty,
                                tag: wr_tag, data: wr_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign rd_valid = lines_q[rd_idx].valid;
    assign rd_dirty = lines_q[rd_idx].dirty;
    assign rd_tag   = lines_q[rd_idx].tag;
    assign rd_data  = lines_q[rd_idx].data;

endmodule

// File: rtl/dmc_lookup.sv
module dmc_lookup #(
    parameter int unsigned TAG_W = 5
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    assign hit = line_valid && (line_tag == req_tag);
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wb,
    input  logic                    cfg_walloc,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ack,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    hit_pulse,
    output logic                    miss_pulse,
    output logic [IDX_W-1:0]        lk_idx,
    output logic [ADDR_W-IDX_W-1:0] lk_tag,
    input  logic                    lk_hit,
    input  logic                    ln_valid,
    input  logic                    ln_dirty,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  logic [DATA_W-1:0]       ln_data,
    output logic                    wr_en,
    output logic                    wr_valid,
    output logic                    wr_dirty,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0]       wr_data
);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        dmc_state_e        st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              hit;
        logic              miss;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] q_idx;
    logic [TAG_W-1:0] q_tag;

    assign q_idx  = ctl_q.addr[IDX_W-1:0];
    assign q_tag  = ctl_q.addr[ADDR_W-1:IDX_W];
    assign lk_idx = (ctl_q.st == ST_IDLE) ? cpu_addr[IDX_W-1:0] : q_idx;
    assign lk_tag = (ctl_q.st == ST_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : q_tag;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.hit  = 1'b0;
        ctl_d.miss = 1'b0;
        wr_en      = 1'b0;
        wr_valid   = ln_valid;
        wr_dirty   = ln_dirty;
        wr_tag     = ln_tag;
        wr_data    = ln_data;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = ctl_q.addr;
        mem_wdata  = ctl_q.wdata;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.we    = cpu_we;
                    ctl_d.addr  = cpu_addr;
                    ctl_d.wdata = cpu_wdata;
                    if (lk_hit) begin
                        ctl_d.hit = 1'b1;
                        if (!cpu_we) begin
                            ctl_d.rdata = ln_data;
                            ctl_d.st    = ST_RESP;
                        end else begin
                            wr_en    = 1'b1;
                            wr_data  = cpu_wdata;
                            wr_dirty = cfg_wb ? 1'b1 : ln_dirty;
                            ctl_d.st = cfg_wb ? ST_RESP : ST_WMEM;
                        end
                    end else begin
                        ctl_d.miss = 1'b1;
                        if (cpu_we && !cfg_walloc)    ctl_d.st = ST_WMEM;
                        else if (ln_valid && ln_dirty) ctl_d.st = ST_WBACK;
                        else                           ctl_d.st = ST_FETCH;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ln_tag, q_idx};
                mem_wdata = ln_data;
                if (mem_ack) ctl_d.st = ST_FETCH;
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en    = 1'b1;
                    wr_valid = 1'b1;
                    wr_tag   = q_tag;
                    if (ctl_q.we) begin
                        wr_data  = ctl_q.wdata;
                        wr_dirty = cfg_wb;
                        ctl_d.st = cfg_wb ? ST_RESP : ST_WMEM;
                    end else begin
                        wr_data     = mem_rdata;
                        wr_dirty    = 1'b0;
                        ctl_d.rdata = mem_rdata;
                        ctl_d.st    = ST_RESP;
                    end
                end
            end
            ST_WMEM: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) ctl_d.st = ST_RESP;
            end
            ST_RESP: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ack    = (ctl_q.st == ST_RESP);
    assign cpu_rdata  = ctl_q.rdata;
    assign hit_pulse  = ctl_q.hit;
    assign miss_pulse = ctl_q.miss;

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wb,
    input  logic              cfg_walloc,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hit_pulse,
    output logic              miss_pulse
);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic              ln_valid;
    logic              ln_dirty;
    logic [TAG_W-1:0]  ln_tag;
    logic [DATA_W-1:0] ln_data;
    logic              wr_en;
    logic              wr_valid;
    logic              wr_dirty;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    dmc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_valid (ln_valid),
        .rd_dirty (ln_dirty),
        .rd_tag   (ln_tag),
        .rd_data  (ln_data),
        .wr_en    (wr_en),
        .wr_idx   (lk_idx),
        .wr_valid (wr_valid),
        .wr_dirty (wr_dirty),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    dmc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .line_valid (ln_valid),
        .line_tag   (ln_tag),
        .req_tag    (lk_tag),
        .hit        (lk_hit)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wb     (cfg_wb),
        .cfg_walloc (cfg_walloc),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ack    (cpu_ack),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .hit_pulse  (hit_pulse),
        .miss_pulse (miss_pulse),
        .lk_idx     (lk_idx),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .ln_valid   (ln_valid),
        .ln_dirty   (ln_dirty),
        .ln_tag     (ln_tag),
        .ln_data    (ln_data),
        .wr_en      (wr_en),
        .wr_valid   (wr_valid),
        .wr_dirty   (wr_dirty),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data)
    );

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wb,
    input logic              cpu_ack,
    input logic              hit_pulse,
    input logic              miss_pulse,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              wr_en,
    input logic              wr_dirty,
    input logic              ln_dirty
);
    // R11
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_pulse && miss_pulse));

    // R5
    wt_no_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_wb && !ln_dirty) |-> !wr_dirty);

    // R6
    wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pulse && cfg_wb) |-> !mem_req);
endmodule

bind dmc_cache dmc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wb     (cfg_wb),
    .cpu_ack    (cpu_ack),
    .hit_pulse  (hit_pulse),
    .miss_pulse (miss_pulse),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .wr_en      (wr_en),
    .wr_dirty   (wr_dirty),
    .ln_dirty   (ln_dirty)
);

// File: tb/dmc_cache_test.sv
`timescale 1ns/1ps
module dmc_cache_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wb = 1'b0;
    logic        cfg_walloc = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        hit_pulse;
    logic        miss_pulse;

    always #4 clk = ~clk;

    dmc_cache uut (
        .clk(clk), .rst_n(rst_n), .cfg_wb(cfg_wb), .cfg_walloc(cfg_walloc),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_pulse(hit_pulse), .miss_pulse(miss_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] mem [256];
    int   n_wr, n_rd;
    bit   first_seen;
    logic first_we;
    logic [7:0] first_wr_addr;
    bit   wr_seen;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: latency 1 or 2 cycles chosen by address bit 0
    initial begin
        int wait_cnt;
        for (int a = 0; a < 256; a++) mem[a] = 16'hA000 | 16'(a);
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt >= 1 + int'(mem_addr[0])) begin
                    if (!first_seen) begin
                        first_seen = 1'b1;
                        first_we   = mem_we;
                    end
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        if (!wr_seen) begin
                            wr_seen       = 1'b1;
                            first_wr_addr = mem_addr;
                        end
                        n_wr++;
                    end else begin
                        mem_rdata = mem[mem_addr];
                        n_rd++;
                    end
                    mem_ack = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic access(input logic we, input logic [7:0] addr,
                          input logic [15:0] wdata, output logic [15:0] rdata,
                          output int hits, output int misses, output int cyc);
        n_wr = 0; n_rd = 0; first_seen = 1'b0; wr_seen = 1'b0;
        first_we = 1'b0; first_wr_addr = '0;
        hits = 0; misses = 0; cyc = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        forever begin
            @(negedge clk);
            cyc++;
            if (hit_pulse)  hits++;
            if (miss_pulse) misses++;
            if (cpu_ack) break;
        end
        rdata   = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    typedef struct packed {
        logic        wb;
        logic        walloc;
        logic        we;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic        hit;
        logic [15:0] rdata;
        logic [1:0]  nwr;
        logic [1:0]  nrd;
        logic [7:0]  waddr;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,8'h08,16'h0000,1'b0,16'hA008,2'd0,2'd1,8'h00}, // R1 R4 cold read miss
        '{1'b0,1'b1,1'b0,8'h08,16'h0000,1'b1,16'hA008,2'd0,2'd0,8'h00}, // R3 read hit
        '{1'b0,1'b1,1'b1,8'h08,16'h1111,1'b1,16'h0000,2'd1,2'd0,8'h08}, // R5 write-through hit
        '{1'b0,1'b1,1'b0,8'h08,16'h0000,1'b1,16'h1111,2'd0,2'd0,8'h00}, // R5 line updated
        '{1'b0,1'b1,1'b0,8'h10,16'h0000,1'b0,16'hA010,2'd0,2'd1,8'h00}, // R2 R5 clean victim, no write
        '{1'b0,1'b1,1'b1,8'h21,16'h2222,1'b0,16'h0000,2'd1,2'd1,8'h21}, // R8 allocate, write-through
        '{1'b0,1'b1,1'b0,8'h21,16'h0000,1'b1,16'h2222,2'd0,2'd0,8'h00}, // R8 allocated line
        '{1'b1,1'b1,1'b1,8'h21,16'h3333,1'b1,16'h0000,2'd0,2'd0,8'h00}, // R6 write-back hit
        '{1'b1,1'b1,1'b0,8'h21,16'h0000,1'b1,16'h3333,2'd0,2'd0,8'h00}, // R6 cached value
        '{1'b1,1'b1,1'b0,8'h41,16'h0000,1'b0,16'hA041,2'd1,2'd1,8'h21}, // R7 dirty victim first
        '{1'b1,1'b1,1'b1,8'h42,16'h4444,1'b0,16'h0000,2'd0,2'd1,8'h00}, // R8 allocate, write-back
        '{1'b1,1'b1,1'b0,8'h42,16'h0000,1'b1,16'h4444,2'd0,2'd0,8'h00}, // R8 cache only
        '{1'b1,1'b1,1'b0,8'h21,16'h0000,1'b0,16'h3333,2'd0,2'd1,8'h00}, // R7 written-back data
        '{1'b1,1'b0,1'b1,8'h0A,16'h5555,1'b0,16'h0000,2'd1,2'd0,8'h0A}, // R9 write-around
        '{1'b1,1'b0,1'b0,8'h42,16'h0000,1'b1,16'h4444,2'd0,2'd0,8'h00}, // R9 line untouched
        '{1'b1,1'b0,1'b0,8'h0A,16'h0000,1'b0,16'h5555,2'd1,2'd1,8'h42}, // R9 R7 still dirty
        '{1'b1,1'b0,1'b1,8'h0A,16'h6666,1'b1,16'h0000,2'd0,2'd0,8'h00}, // R6 hit ignores alloc
        '{1'b0,1'b0,1'b1,8'h13,16'h7777,1'b0,16'h0000,2'd1,2'd0,8'h13}, // R9 around, write-through
        '{1'b0,1'b0,1'b0,8'h13,16'h0000,1'b0,16'h7777,2'd0,2'd1,8'h00}, // R9 not allocated
        '{1'b0,1'b0,1'b0,8'h0A,16'h0000,1'b1,16'h6666,2'd0,2'd0,8'h00}  // R2 index 2 tag 1
    };

    initial begin
        logic [15:0] rd;
        int hits, misses, cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cpu_ack && !mem_req && !hit_pulse && !miss_pulse, "R1", "idle outputs in reset",
            {cpu_ack, mem_req, hit_pulse, miss_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ack && !mem_req, "R1", "idle after reset", {cpu_ack, mem_req}, 0);

        for (int i = 0; i < NV; i++) begin
            cfg_wb     = VECS[i].wb;
            cfg_walloc = VECS[i].walloc;
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rd, hits, misses, cyc);
            // R10 exactly one event of the right kind
            chk(hits == int'(VECS[i].hit) && misses == int'(!VECS[i].hit), "R10",
                $sformatf("vec%0d hit/miss", i), {hits[15:0], misses[15:0]},
                {15'd0, VECS[i].hit, 15'd0, !VECS[i].hit});
            if (!VECS[i].we)
                chk(rd == VECS[i].rdata, "R3/R4", $sformatf("vec%0d rdata", i), rd, VECS[i].rdata);
            chk(n_wr == int'(VECS[i].nwr), "R5-R9", $sformatf("vec%0d mem writes", i),
                n_wr, VECS[i].nwr);
            chk(n_rd == int'(VECS[i].nrd), "R4/R7-R9", $sformatf("vec%0d mem reads", i),
                n_rd, VECS[i].nrd);
            if (VECS[i].nwr != 0)
                chk(first_wr_addr == VECS[i].waddr, "R7", $sformatf("vec%0d write addr", i),
                    first_wr_addr, VECS[i].waddr);
            if (VECS[i].nwr != 0 && VECS[i].nrd != 0 && !VECS[i].we)
                chk(first_we == 1'b1, "R7", $sformatf("vec%0d write before read", i),
                    first_we, 1);
            if (VECS[i].hit && VECS[i].nwr == 0)
                chk(cyc == 1, "R3", $sformatf("vec%0d hit latency", i), cyc, 1);
            @(negedge clk);
            chk(!cpu_ack, "R11", $sformatf("vec%0d ack one cycle", i), cpu_ack, 0);
        end

        // R6 memory still holds the old value while the line is dirty
        chk(mem[8'h0A] == 16'h5555, "R6", "memory not written on write-back hit",
            mem[8'h0A], 16'h5555);

        // R1 a second reset invalidates every line
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cpu_ack && !hit_pulse && !miss_pulse, "R1", "outputs in second reset",
            {cpu_ack, hit_pulse, miss_pulse}, 0);
        rst_n = 1'b1;
        cfg_wb = 1'b1; cfg_walloc = 1'b1;
        @(negedge clk);
        access(1'b0, 8'h21, 16'h0, rd, hits, misses, cyc);
        chk(misses == 1 && hits == 0, "R1", "cached address misses after reset",
            misses, 1);
        chk(rd == 16'h3333 && n_rd == 1 && n_wr == 0, "R1", "refetch after reset",
            rd, 16'h3333);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule